// File: doc/BRIEF.md
# BCD Calendar Counter with Write Control

This block keeps wall-clock time as a chain of BCD counters: seconds, minutes, 24-hour hours, a weekday, day of month, month and a two-digit year covering 2000 to 2099. A divider counts prescaler enable pulses and produces one tick per second. Each tick advances the seconds, and carries ripple up the chain. Day rollover follows the length of the current month, and February has 29 days in every year divisible by four.

An access port fills the counters from a serial write frame. The block does not shift the bits itself. It sees only a start strobe, a byte bus with one strobe per field, a separate strobe for the seconds byte and an indication that chip select has fallen. A write start freezes the chain and zeroes the divider. The minute strobe arrives while the seconds byte is still being shifted in, and one cycle after it the date and time fields are copied into the counters, with any day beyond the month's end clamped to the last valid day. The seconds byte is held back until chip select falls, and it is loaded then without any check. Counting resumes from an empty divider at that point. A seconds value that does not exist is cleared on the first tick, and that tick also carries into the minutes.

Top module: `rtc_calendar_core`

## Requirements
- R1: After reset the outputs read 00:00:00, weekday 0, day 01, month 01, year 00, and the block is not frozen.
- R2: While not frozen, one tick occurs on every DIV_N-th prescaler enable pulse, and the seconds then step in BCD from 00 to 59 and wrap to 00 with a carry.
- R3: Minutes wrap 59 to 00 with a carry into the hours. Hours wrap 23 to 00 with a day carry. The weekday steps 0 to 6 and wraps to 0 on each day carry.
- R4: The day wraps to 01 after 28, 29, 30 or 31 days according to month and year. February has 29 days when the binary value of the year is divisible by 4. Months 04, 06, 09 and 11 have 30 days. Month 12 wraps to 01 and increments the year, and year 99 wraps to 00.
- R5: A write start freezes all counters and zeroes the divider. While frozen, prescaler pulses change no output, and only a field commit or a seconds load alters the counters.
- R6: fld_we bit 0 writes the year, bit 1 the month, bit 2 the day, bit 3 the weekday (fld_data[2:0]), bit 4 the hour and bit 5 the minute into staging. One cycle after the minute strobe, all staged fields are loaded into the counters, and a day above the month length is clamped to that month's last day.
- R7: The staged seconds byte (sec_we) is loaded into the seconds counter only when chip select falls during a write, with no validity check. The seconds output is unchanged before that event.
- R8: The chip-select fall that ends a write clears the freeze, and the first tick after it comes on exactly the DIV_N-th following prescaler pulse.
- R9: A tick that finds the seconds non-BCD or above 59 sets them to 00 and carries into the minutes.
- R10: Field strobes, the seconds strobe and a chip-select fall have no effect while no write is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| presc_en | input | 1 | Prescaler clock enable, DIV_N pulses make one second |
| wr_start | input | 1 | Write command decoded, freezes counting |
| fld_data | input | 8 | Parallel byte for the field and seconds strobes |
| fld_we | input | 6 | Per-field load strobes (year, month, day, weekday, hour, minute) |
| sec_we | input | 1 | Seconds byte strobe into staging |
| cs_fall | input | 1 | Chip select has gone from high to low |
| o_sec | output | 8 | Seconds, BCD |
| o_min | output | 8 | Minutes, BCD |
| o_hour | output | 8 | Hours, BCD 00 to 23 |
| o_wday | output | 3 | Weekday 0 to 6 |
| o_day | output | 8 | Day of month, BCD |
| o_mon | output | 8 | Month, BCD |
| o_year | output | 8 | Year, BCD 00 to 99 |

## Verification
The bench builds the block with DIV_N = 4, so one second costs only four enable pulses. At that divider setting, the bench can step every month-end of all hundred years through its rollover, one write frame each, and it can also run a full hour of consecutive seconds. The small divider also makes the exact restart distance after chip select falls visible pulse by pulse. Invalid seconds patterns and day clamping in short and leap Februaries are checked against the bench's own arithmetic.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  typedef struct packed {
    logic [7:0] year;
    logic [7:0] mon;
    logic [7:0] day;
    logic [2:0] wday;
    logic [7:0] hour;
    logic [7:0] min;
  } cal_fields_t;

  function automatic logic [6:0] bcd2bin(input logic [7:0] b);
    return 7'(b[7:4]) * 7'd10 + 7'(b[3:0]);
  endfunction

  function automatic logic leap_year(input logic [7:0] yr);
    logic [6:0] y;
    y = bcd2bin(yr);
    return y[1:0] == 2'b00;
  endfunction

  function automatic logic [7:0] month_len(input logic [7:0] mon, input logic [7:0] yr);
    case (mon)
      8'h02:                     return leap_year(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                   return 8'h31;
    endcase
  endfunction

  function automatic logic sec_ok(input logic [7:0] s);
    return (s[3:0] <= 4'd9) && (s <= 8'h59);
  endfunction

  // {carry, next}: wraps to base when v has reached top
  function automatic logic [8:0] bcd_step(input logic [7:0] v, input logic [7:0] top,
                                          input logic [7:0] base);
    if (v >= top)             return {1'b1, base};
    else if (v[3:0] >= 4'd9)  return {1'b0, v[7:4] + 4'd1, 4'd0};
    else                      return {1'b0, v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [7:0] clamp_day(input logic [7:0] day, input logic [7:0] mon,
                                           input logic [7:0] yr);
    logic [7:0] lim;
    lim = month_len(mon, yr);
    return (day > lim) ? lim : day;
  endfunction

endpackage

// File: rtl/rtc_sec_divider.sv
module rtc_sec_divider #(
  parameter int DIV_N = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic presc_en,
  input  logic clear,
  input  logic hold,
  output logic tick
);
  localparam int DIV_W = (DIV_N > 1) ? $clog2(DIV_N) : 1;

  logic [DIV_W-1:0] cnt;
  logic             at_last;

  assign at_last = (cnt == DIV_W'(DIV_N - 1));
  assign tick    = presc_en && !clear && !hold && at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (clear || hold)  cnt <= '0;
    else if (presc_en)       cnt <= at_last ? '0 : cnt + DIV_W'(1);
  end

  // R5
  frozen_div_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (cnt == '0));

endmodule

// File: rtl/rtc_write_ctl.sv
module rtc_write_ctl import rtc_cal_pkg::*; (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_start,
  input  logic [7:0]  fld_data,
  input  logic [5:0]  fld_we,
  input  logic        sec_we,
  input  logic        cs_fall,
  output logic        halted,
  output logic        commit,
  output logic        sec_load,
  output cal_fields_t stage,
  output logic [7:0]  stage_sec
);
  assign sec_load = cs_fall && halted && !wr_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halted    <= 1'b0;
      commit    <= 1'b0;
      stage     <= '0;
      stage_sec <= '0;
    end else begin
      if (wr_start)      halted <= 1'b1;
      else if (sec_load) halted <= 1'b0;
      commit <= fld_we[5] && halted;
      if (halted) begin
        if (fld_we[0]) stage.year <= fld_data;
        if (fld_we[1]) stage.mon  <= fld_data;
        if (fld_we[2]) stage.day  <= fld_data;
        if (fld_we[3]) stage.wday <= fld_data[2:0];
        if (fld_we[4]) stage.hour <= fld_data;
        if (fld_we[5]) stage.min  <= fld_data;
        if (sec_we)    stage_sec  <= fld_data;
      end
    end
  end

  // R5
  start_freezes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start |=> halted);

  // R8
  cs_fall_resumes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_fall && halted && !wr_start) |=> !halted);

  // R10
  idle_no_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !halted |=> !commit);

endmodule

// File: rtl/rtc_count_chain.sv
module rtc_count_chain import rtc_cal_pkg::*; (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        commit,
  input  cal_fields_t stage,
  input  logic        sec_load,
  input  logic [7:0]  sec_in,
  output logic [7:0]  sec,
  output logic [7:0]  min,
  output logic [7:0]  hour,
  output logic [2:0]  wday,
  output logic [7:0]  day,
  output logic [7:0]  mon,
  output logic [7:0]  year
);
  logic       sec_wrap;
  logic [8:0] sec_st, min_st, hour_st, day_st, mon_st, yr_st;
  logic       c_min, c_hour, c_day, c_mon, c_year;

  assign sec_wrap = !sec_ok(sec) || (sec == 8'h59);
  assign sec_st   = bcd_step(sec,  8'h59, 8'h00);
  assign min_st   = bcd_step(min,  8'h59, 8'h00);
  assign hour_st  = bcd_step(hour, 8'h23, 8'h00);
  assign day_st   = bcd_step(day,  month_len(mon, year), 8'h01);
  assign mon_st   = bcd_step(mon,  8'h12, 8'h01);
  assign yr_st    = bcd_step(year, 8'h99, 8'h00);

  // carry events along the chain
  assign c_min  = tick   && sec_wrap;
  assign c_hour = c_min  && min_st[8];
  assign c_day  = c_hour && hour_st[8];
  assign c_mon  = c_day  && day_st[8];
  assign c_year = c_mon  && mon_st[8];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec <= 8'h00; min <= 8'h00; hour <= 8'h00; wday <= 3'd0;
      day <= 8'h01; mon <= 8'h01; year <= 8'h00;
    end else begin
      if (commit) begin
        min  <= stage.min;
        hour <= stage.hour;
        wday <= stage.wday;
        day  <= clamp_day(stage.day, stage.mon, stage.year);
        mon  <= stage.mon;
        year <= stage.year;
      end
      if (sec_load) sec <= sec_in;
      if (tick)     sec <= sec_wrap ? 8'h00 : sec_st[7:0];
      if (c_min)    min  <= min_st[7:0];
      if (c_hour)   hour <= hour_st[7:0];
      if (c_day) begin
        day  <= day_st[7:0];
        wday <= (wday == 3'd6) ? 3'd0 : wday + 3'd1;
      end
      if (c_mon)    mon  <= mon_st[7:0];
      if (c_year)   year <= yr_st[7:0];
    end
  end

  // R5
  quiet_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !commit && !sec_load) |=> $stable({sec, min, hour, wday, day, mon, year}));

  // R9
  sec_valid_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> sec_ok(sec));

  // R6
  day_clamped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (day <= month_len(mon, year)));

  // R3
  day_carry_midnight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    c_day |=> (sec == 8'h00 && min == 8'h00 && hour == 8'h00));

endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core import rtc_cal_pkg::*; #(
  parameter int DIV_N = 32768
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       presc_en,
  input  logic       wr_start,
  input  logic [7:0] fld_data,
  input  logic [5:0] fld_we,
  input  logic       sec_we,
  input  logic       cs_fall,
  output logic [7:0] o_sec,
  output logic [7:0] o_min,
  output logic [7:0] o_hour,
  output logic [2:0] o_wday,
  output logic [7:0] o_day,
  output logic [7:0] o_mon,
  output logic [7:0] o_year
);
  logic        halted, commit, sec_load, tick;
  cal_fields_t stage;
  logic [7:0]  stage_sec;

  rtc_write_ctl u_wctl (
    .clk, .rst_n, .wr_start, .fld_data, .fld_we, .sec_we, .cs_fall,
    .halted, .commit, .sec_load, .stage, .stage_sec
  );

  rtc_sec_divider #(.DIV_N(DIV_N)) u_div (
    .clk, .rst_n, .presc_en, .clear(wr_start), .hold(halted), .tick
  );

  rtc_count_chain u_chain (
    .clk, .rst_n, .tick, .commit, .stage, .sec_load, .sec_in(stage_sec),
    .sec(o_sec), .min(o_min), .hour(o_hour), .wday(o_wday),
    .day(o_day), .mon(o_mon), .year(o_year)
  );

endmodule

// File: tb/rtc_calendar_core_test.sv
`timescale 1ns/1ps
module rtc_calendar_core_test;
  localparam int DIVN = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic presc_en = 1'b0, wr_start = 1'b0, sec_we = 1'b0, cs_fall = 1'b0;
  logic [7:0] fld_data = '0;
  logic [5:0] fld_we = '0;
  logic [7:0] o_sec, o_min, o_hour, o_day, o_mon, o_year;
  logic [2:0] o_wday;

  int n_chk = 0, n_bad = 0;
  int m_y, m_mo, m_d, m_wd, m_h, m_mi, m_s;

  always #2.5 clk = ~clk;

  rtc_calendar_core #(.DIV_N(DIVN)) uut (
    .clk, .rst_n, .presc_en, .wr_start, .fld_data, .fld_we, .sec_we, .cs_fall,
    .o_sec, .o_min, .o_hour, .o_wday, .o_day, .o_mon, .o_year
  );

  function automatic logic [7:0] tobcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  // month length: odd months up to July and even months from August have 31
  function automatic int bdim(input int mo, input int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo < 8)  return 30 + (mo % 2);
    return 31 - (mo % 2);
  endfunction

  function automatic logic [55:0] act_vec();
    return {o_sec, o_min, o_hour, 5'b0, o_wday, o_day, o_mon, o_year};
  endfunction

  function automatic logic [55:0] exp_vec();
    return {tobcd(m_s), tobcd(m_mi), tobcd(m_h), 5'b0, 3'(m_wd),
            tobcd(m_d), tobcd(m_mo), tobcd(m_y)};
  endfunction

  task automatic chk(input string req, input logic [55:0] act, input logic [55:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic m_set(input int y, mo, d, wd, h, mi, s);
    m_y = y; m_mo = mo; m_d = d; m_wd = wd; m_h = h; m_mi = mi; m_s = s;
  endtask

  task automatic m_tick();
    if (m_s < 59) begin m_s++; return; end
    m_s = 0; m_mi++;
    if (m_mi < 60) return;
    m_mi = 0; m_h++;
    if (m_h < 24) return;
    m_h = 0; m_wd = (m_wd + 1) % 7; m_d++;
    if (m_d <= bdim(m_mo, m_y)) return;
    m_d = 1; m_mo++;
    if (m_mo <= 12) return;
    m_mo = 1; m_y = (m_y + 1) % 100;
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic pulses(input int n);
    presc_en = 1'b1;
    repeat (n) cyc();
    presc_en = 1'b0;
  endtask

  task automatic wopen(input logic [7:0] y, mo, d, input logic [2:0] wd,
                       input logic [7:0] h, mi, s);
    logic [7:0] v[6];
    v = '{y, mo, d, {5'b0, wd}, h, mi};
    wr_start = 1'b1; cyc(); wr_start = 1'b0;
    for (int i = 0; i < 6; i++) begin
      fld_we = 6'(1 << i); fld_data = v[i]; cyc();
    end
    fld_we = '0;
    sec_we = 1'b1; fld_data = s; cyc(); sec_we = 1'b0;
    cyc();
  endtask

  task automatic wclose();
    cs_fall = 1'b1; cyc(); cs_fall = 1'b0;
  endtask

  initial begin
    #(150000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [55:0] snap;
    logic [7:0] badsec[5];
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();
    m_set(0, 1, 1, 0, 0, 0, 0);
    chk("R1 reset", act_vec(), exp_vec());

    // R10: strobes and chip-select fall outside a write
    fld_we = 6'h3F; fld_data = 8'h12; sec_we = 1'b1; cyc();
    fld_we = '0; sec_we = 1'b0; cs_fall = 1'b1; cyc(); cs_fall = 1'b0; cyc();
    chk("R10 ignored", act_vec(), exp_vec());

    // R2: one tick per DIVN pulses
    pulses(DIVN - 1);
    chk("R2 before tick", act_vec(), exp_vec());
    pulses(1); m_tick();
    chk("R2 tick", act_vec(), exp_vec());

    // R5/R8: partial divider, then write, frozen, exact restart
    pulses(DIVN - 1);
    wopen(8'h24, 8'h03, 8'h15, 3'd2, 8'h22, 8'h00, 8'h00);
    snap = act_vec();
    pulses(3 * DIVN);
    chk("R5 frozen", act_vec(), snap);
    wclose();
    m_set(24, 3, 15, 2, 22, 0, 0);
    chk("R7 loaded", act_vec(), exp_vec());
    pulses(DIVN - 1);
    chk("R8 no early tick", act_vec(), exp_vec());
    pulses(1); m_tick();
    chk("R8 first tick", act_vec(), exp_vec());

    // R2/R3: one hour of consecutive seconds
    for (int k = 0; k < 3660; k++) begin
      pulses(DIVN); m_tick();
      chk("R3 seconds sweep", act_vec(), exp_vec());
    end

    // R4: every month end of every year, at 23:59:59
    for (int y = 0; y < 100; y++) begin
      for (int mo = 1; mo <= 12; mo++) begin
        wopen(tobcd(y), tobcd(mo), tobcd(bdim(mo, y)), 3'd6, 8'h23, 8'h59, 8'h59);
        wclose();
        m_set(y, mo, bdim(mo, y), 6, 23, 59, 59);
        pulses(DIVN); m_tick();
        chk("R4 month end", act_vec(), exp_vec());
      end
    end

    // R6: day clamping at commit, seen before chip select falls
    wopen(8'h10, 8'h04, 8'h31, 3'd1, 8'h05, 8'h06, 8'h07);
    chk("R6 clamp april", {32'b0, o_day, o_mon, o_year}, {32'b0, 8'h30, 8'h04, 8'h10});
    wclose();
    wopen(8'h23, 8'h02, 8'h30, 3'd1, 8'h05, 8'h06, 8'h07);
    chk("R6 clamp feb", {32'b0, o_day, o_mon, o_year}, {32'b0, 8'h28, 8'h02, 8'h23});
    wclose();
    wopen(8'h24, 8'h02, 8'h31, 3'd1, 8'h05, 8'h06, 8'h07);
    chk("R6 clamp leap", {32'b0, o_day, o_mon, o_year}, {32'b0, 8'h29, 8'h02, 8'h24});
    wclose();
    wopen(8'h00, 8'h01, 8'h31, 3'd1, 8'h05, 8'h06, 8'h07);
    chk("R6 no clamp", {32'b0, o_day, o_mon, o_year}, {32'b0, 8'h31, 8'h01, 8'h00});
    wclose();

    // R7/R9: invalid seconds load raw, clear on first tick with minute carry
    badsec = '{8'h5A, 8'h60, 8'h7F, 8'h3C, 8'hFF};
    for (int i = 0; i < 5; i++) begin
      wopen(8'h50, 8'h06, 8'h10, 3'd3, 8'h10, 8'h20, badsec[i]);
      chk("R7 sec held until cs fall", {48'b0, o_sec}, {48'b0, 8'h07});
      wclose();
      chk("R7 raw sec load", {48'b0, o_sec}, {48'b0, badsec[i]});
      pulses(DIVN);
      m_set(50, 6, 10, 3, 10, 21, 0);
      chk("R9 invalid sec cleared", act_vec(), exp_vec());
      // restore a known seconds value for the next pass
      wopen(8'h50, 8'h06, 8'h10, 3'd3, 8'h10, 8'h20, 8'h07);
      wclose();
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule